// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external, fully static asynchronous SRAM with 256K words of 4 bits. The host presents one word-sized read or write at a time over a request/ready handshake. The controller turns each request into a strobe sequence for the memory: an 18-bit address, active-low chip select, active-low write enable and active-low output enable. The 4-bit data bus is split into a driven value, a sampled value and a drive enable, so the pad ring can build the tri-state buffer.

Every strobe is a flop output, so no decode glitch reaches the asynchronous part. A write is set up one cycle ahead, pulsed for `WRITE_WAIT` cycles with output enable held high, and then held for one cycle before the bus is released. A read keeps chip select and output enable low for `READ_WAIT` cycles. The word is captured in the last of those cycles and returned with a single-cycle valid pulse. Between requests, chip select is high, so the memory rests in standby.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after reset, chip select, write enable and output enable are high, the bus drive enable is low, `req_ready` is high and `rd_valid` is low. A reset during an access returns every strobe to these values.
- R2: Whenever `req_ready` is high, chip select, write enable and output enable are all high. Chip select is low only while an access is in progress.
- R3: A write drives chip select low with the new address and data one cycle before write enable falls. Write enable stays low for exactly `WRITE_WAIT` cycles. It rises one cycle before chip select rises and the bus drive enable falls.
- R4: Output enable stays high throughout a write. The bus drive enable is never high in a cycle where output enable is low, and output enable never falls in the cycle right after the bus was driven.
- R5: A read holds chip select and output enable low for exactly `READ_WAIT` cycles, with write enable high and the bus not driven.
- R6: The value on `mem_dq_in` in the last read-access cycle appears on `rd_data`. It is marked by `rd_valid` high for exactly one cycle, in the cycle `req_ready` returns high.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for `READ_WAIT` cycles for a read, or `WRITE_WAIT + 2` cycles for a write. A new request may be presented in the cycle `req_ready` returns.
- R8: The memory address does not change while chip select stays low.
- R9: With `req_valid` low, the controller issues no strobe: chip select, write enable and output enable stay high.
- R10: The memory holds the host's write data at the host's address when write enable rises. A later read of that address, including an overwrite, returns the latest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, a request is taken this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| rd_data | output | 4 | Captured read word |
| mem_addr | output | 18 | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 4 | Value driven onto the data bus |
| mem_dq_in | input | 4 | Value sampled from the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench builds the controller with `READ_WAIT = 3` and `WRITE_WAIT = 1`, so the read and write windows differ and a mix-up between them shows in the busy counts. `WRITE_WAIT = 1` loads the counter with zero, so the write pulse ends in its first cycle. That is the shortest legal pulse, and the path most prone to an off-by-one. A small tagged memory model in the bench commits data on the rising edge of write enable. It drives the bus only while a read is strobed, so early or late capture, address aliasing in the high bits and overwrites all show up as wrong read data.

// File: rtl/sramc_pkg.sv
// Shared types for the asynchronous SRAM controller.
// Assumes: one access in flight at a time.
package sramc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACCESS
    } sramc_state_e;
endpackage

// File: rtl/sramc_wait_cnt.sv
// Wait-state down counter: loaded with (cycles - 1) when a timed phase
// begins, reports done in the final cycle of that phase.
// Assumes: load values never exceed MAX_LOAD.
module sramc_wait_cnt #(
    parameter int MAX_LOAD = 1,
    localparam int CNT_W   = (MAX_LOAD > 0) ? $clog2(MAX_LOAD + 1) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    generate
        if (MAX_LOAD == 0) begin : g_no_cnt
            // every timed phase is one cycle long, no storage needed
            assign done = 1'b1;
        end else begin : g_cnt
            logic [CNT_W-1:0] cnt_q;

            // count down the remaining cycles of the current phase
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (load)
                    cnt_q <= load_val;
                else if (cnt_q != '0)
                    cnt_q <= cnt_q - 1'b1;
            end

            assign done = (cnt_q == '0);
        end
    endgenerate
endmodule

// File: rtl/sramc_rd_capture.sv
// Read-return register: samples the memory bus on request and raises a
// one-cycle valid flag alongside the held word.
// Assumes: capture is a single-cycle strobe from the sequencer.
module sramc_rd_capture #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] word_q,
    output logic              valid_q
);
    // hold the captured word until the next read replaces it
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (capture)
            word_q <= bus_in;
    end

    // valid follows the capture strobe by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= 1'b0;
        else
            valid_q <= capture;
    end
endmodule

// File: rtl/async_sram_ctrl.sv
// Asynchronous SRAM access controller: one host word per request, turned
// into registered chip-select / write-enable / output-enable sequences.
// Assumes: READ_WAIT >= 1 and WRITE_WAIT >= 1, chosen from the clock period
// and the memory speed grade; the pad ring builds the tri-state buffer from
// mem_dq_out / mem_dq_oe.
module async_sram_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 4,
    parameter int READ_WAIT  = 2,
    parameter int WRITE_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int RD_LOAD  = READ_WAIT - 1;
    localparam int WR_LOAD  = WRITE_WAIT - 1;
    localparam int MAX_LOAD = (RD_LOAD > WR_LOAD) ? RD_LOAD : WR_LOAD;
    localparam int CNT_W    = (MAX_LOAD > 0) ? $clog2(MAX_LOAD + 1) : 1;

    sramc_state_e     state_q, state_nx;
    logic             accept;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_done;
    logic             capture;

    assign accept  = req_valid && req_ready;
    assign capture = (state_q == ST_RACCESS) && cnt_done;

    // sequencer next state and wait-counter loading
    always_comb begin
        state_nx = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        state_nx = ST_WSETUP;
                    end else begin
                        state_nx = ST_RACCESS;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(RD_LOAD);
                    end
                end
            end
            ST_WSETUP: begin
                state_nx = ST_WPULSE;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(WR_LOAD);
            end
            ST_WPULSE:  if (cnt_done) state_nx = ST_WHOLD;
            ST_WHOLD:   state_nx = ST_IDLE;
            ST_RACCESS: if (cnt_done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    // strobes registered from the next state so the memory sees clean edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            req_ready <= 1'b1;
        end else begin
            mem_cs_n  <= (state_nx == ST_IDLE);
            mem_we_n  <= (state_nx != ST_WPULSE);
            mem_oe_n  <= (state_nx != ST_RACCESS);
            mem_dq_oe <= (state_nx == ST_WSETUP) || (state_nx == ST_WPULSE)
                         || (state_nx == ST_WHOLD);
            req_ready <= (state_nx == ST_IDLE);
        end
    end

    // address and write data latched when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_write ? req_wdata : '0;
        end
    end

    sramc_wait_cnt #(
        .MAX_LOAD (MAX_LOAD)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    sramc_rd_capture #(
        .DATA_W (DATA_W)
    ) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .bus_in  (mem_dq_in),
        .word_q  (rd_data),
        .valid_q (rd_valid)
    );

    // ---------------- assertions ----------------
    p_standby_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n));

    p_we_fall_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (!$past(mem_cs_n) && $past(mem_dq_oe) && $stable(mem_addr)));

    p_we_rise_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe));

    p_no_bus_fight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_oe_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    p_read_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n && !mem_dq_oe));

    p_rdvalid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (req_ready && !$past(mem_oe_n)) ##1 !rd_valid);

    p_addr_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));
endmodule

// File: tb/async_sram_ctrl_test.sv
module async_sram_ctrl_test;
    localparam int RW = 3;
    localparam int WW = 1;
    localparam int NV = 13;

    // {write flag, address, write data or expected read data}
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 18'h00001, 4'hA},
        {1'b1, 18'h3FFC2, 4'h5},
        {1'b1, 18'h12343, 4'hF},
        {1'b0, 18'h00001, 4'hA},
        {1'b0, 18'h3FFC2, 4'h5},
        {1'b1, 18'h00001, 4'h3},
        {1'b0, 18'h00001, 4'h3},
        {1'b0, 18'h12343, 4'hF},
        {1'b1, 18'h20004, 4'h0},
        {1'b0, 18'h20004, 4'h0},
        {1'b0, 18'h00005, 4'h0},
        {1'b1, 18'h1FFFF, 4'hC},
        {1'b0, 18'h1FFFF, 4'hC}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        rd_valid;
    logic [3:0]  rd_data;
    logic [17:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [3:0]  mem_dq_out;
    logic [3:0]  mem_dq_in;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;

    always #5 clk = ~clk;

    async_sram_ctrl #(
        .ADDR_W (18), .DATA_W (4), .READ_WAIT (RW), .WRITE_WAIT (WW)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .mem_addr (mem_addr), .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n),
        .mem_oe_n (mem_oe_n), .mem_dq_out (mem_dq_out), .mem_dq_in (mem_dq_in),
        .mem_dq_oe (mem_dq_oe)
    );

    // tagged memory model: commits on the rising edge of write enable
    logic [3:0]  m_data [64];
    logic [17:0] m_tag  [64];
    logic [63:0] m_vld = '0;

    always @(posedge mem_we_n) begin
        if (!mem_cs_n && mem_dq_oe) begin
            m_data[mem_addr[5:0]] <= mem_dq_out;
            m_tag[mem_addr[5:0]]  <= mem_addr;
            m_vld[mem_addr[5:0]]  <= 1'b1;
        end
    end

    always_comb begin
        if (!mem_cs_n && !mem_oe_n && mem_we_n && m_vld[mem_addr[5:0]]
            && m_tag[mem_addr[5:0]] == mem_addr)
            mem_dq_in = m_data[mem_addr[5:0]];
        else
            mem_dq_in = 4'h0;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // protocol monitor on the memory side
    int          we_run = 0;
    int          oe_run = 0;
    logic        prev_cs_n = 1'b1;
    logic        prev_we_n = 1'b1;
    logic [17:0] prev_addr = '0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (!mem_we_n) begin
                if (prev_we_n) check(!mem_cs_n && !prev_cs_n, "R3 cs before we", 32'(prev_cs_n), 0);
                we_run++;
            end else if (we_run > 0) begin
                check(we_run == WW, "R3 we width", we_run, WW);
                check(!mem_cs_n && mem_dq_oe, "R3 hold after we", {mem_cs_n, mem_dq_oe}, 32'h1);
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            else if (oe_run > 0) begin
                check(oe_run == RW, "R5 oe width", oe_run, RW);
                oe_run = 0;
            end
            if (mem_dq_oe) check(mem_oe_n, "R4 oe high while driving", mem_oe_n, 1);
            if (!mem_oe_n) check(mem_we_n && !mem_dq_oe, "R5 read quiet", {mem_we_n, mem_dq_oe}, 32'h2);
            if (req_ready) check(mem_cs_n && mem_we_n && mem_oe_n, "R2 standby", {mem_cs_n, mem_we_n, mem_oe_n}, 32'h7);
            if (!mem_cs_n && !prev_cs_n) check(mem_addr == prev_addr, "R8 addr stable", mem_addr, prev_addr);
        end else begin
            we_run = 0;
            oe_run = 0;
        end
        prev_cs_n = mem_cs_n;
        prev_we_n = mem_we_n;
        prev_addr = mem_addr;
    end

    // one access; called at a negedge with the controller idle
    task automatic run_op(input logic wr, input logic [17:0] a, input logic [3:0] d);
        int busy = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wr ? d : 4'h0;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && busy < 50) begin
            busy++;
            @(negedge clk);
        end
        if (wr) begin
            check(busy == WW + 2, "R7 write busy", busy, WW + 2);
            check(!rd_valid, "R6 no valid on write", rd_valid, 0);
        end else begin
            check(busy == RW, "R7 read busy", busy, RW);
            check(rd_valid && rd_data == d, "R6 R10 read data", {rd_valid, rd_data}, {1'b1, d});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 values while reset is held
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes in reset",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'hE);
        check(req_ready && !rd_valid, "R1 handshake in reset", {req_ready, rd_valid}, 32'h2);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready, "R1 after reset",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 32'h1D);
        mon_en = 1'b1;

        // R9: nothing happens without a request
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(mem_cs_n && mem_we_n && mem_oe_n, "R9 idle", {mem_cs_n, mem_we_n, mem_oe_n}, 32'h7);
        end

        // table walk, back to back (R3 R5 R6 R7 R10)
        for (int i = 0; i < NV; i++)
            run_op(VEC[i][22], VEC[i][21:4], VEC[i][3:0]);

        // R1: reset in the middle of a read
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00001;
        @(negedge clk);
        req_valid = 1'b0;
        mon_en = 1'b0;
        check(!mem_oe_n && !mem_cs_n, "R5 read started", {mem_cs_n, mem_oe_n}, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rd_valid,
              "R1 reset mid read", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rd_valid},
              32'h3A);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        run_op(1'b0, 18'h00001, 4'h3);
        check(req_ready && mem_cs_n, "R2 ends in standby", {req_ready, mem_cs_n}, 32'h3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule